// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

The block owns the refresh duty of a 4096-row dynamic RAM. After reset it waits out the power-up pause. It then runs a fixed number of initialization refresh cycles and raises a ready flag. From then on it issues one refresh cycle per refresh interval. Every cycle it issues is CAS-before-RAS, so the device's own row counter supplies the address and no address bus is needed. WE stays high throughout, so that no cycle can be read as a test-mode entry.

After initialization the sequencer shares the strobes with an access controller through a request and grant pair. Refreshes that come due while the grant is withheld are counted in a small saturating counter. When the grant comes back, they are run back to back. If the access controller signals that an access is waiting, the sequencer gives up the strobes early. It only does so once the backlog has dropped below a yield threshold. All timing is given in nanoseconds and converted to clock cycles at elaboration.

Top module: `drf_refresh_sequencer`

## Requirements
- R1: While rst_ni is low, ras_n_o, cas_n_o and we_n_o are 1, and ready_o and ref_req_o are 0.
- R2: After reset release, cas_n_o and ras_n_o stay high for at least PAUSE_CYC = ceil(PAUSE_NS/CLK_NS) cycles. The first CAS fall comes no more than 2 cycles after that.
- R3: Exactly INIT_CYCLES (default 8) refresh cycles run before ready_o rises. Once high, ready_o stays high. ref_req_o is 0 while ready_o is 0, whatever ref_gnt_i does.
- R4: In every cycle, CAS falls exactly T_CSR = max(1, ceil(CSR_NS/CLK_NS)) cycles before RAS falls. CAS stays low while RAS is low and rises in the same cycle as RAS.
- R5: RAS stays low for exactly T_RAS = ceil(RAS_NS/CLK_NS) cycles. Between two cycles RAS stays high for at least T_RP + T_CSR cycles, where T_RP = max(1, ceil(RC_NS/CLK_NS) - T_RAS).
- R6: we_n_o is 1 at all times.
- R7: After ready, one refresh comes due every INTERVAL_CYC = floor(REFRESH_NS/ROWS/CLK_NS) cycles. If the grant follows the request, one refresh cycle runs per interval, and successive rises of ref_req_o are exactly INTERVAL_CYC apart.
- R8: Refreshes that come due while the grant is withheld are counted, up to PEND_MAX (default 8); further ones are dropped. On grant, that many cycles run back to back.
- R9: ref_req_o is 1 while refreshes are pending and no access is waiting. It stays 1 until the running cycle has finished. A cycle starts only while ref_gnt_i and ref_req_o are both 1. With nothing pending, ref_req_o is 0.
- R10: While acc_wait_i is 1 and fewer than YIELD_THR (default 4) refreshes are pending, ref_req_o is 0. It rises again as soon as acc_wait_i falls, if refreshes are still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_gnt_i | input | 1 | Strobes granted to the sequencer |
| acc_wait_i | input | 1 | Access controller has an access waiting |
| ref_req_o | output | 1 | Sequencer requests the strobes |
| ready_o | output | 1 | Initialization done; host accesses allowed |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low (held high) |

## Verification
The bench builds the block with a 10 ns clock, a 300 ns pause and a refresh period scaled so that the interval is 200 cycles. This brings the pause, the eight init cycles and a dozen deferred intervals into a run of a few thousand cycles. The default strobe timings give 1, 5 and 4 cycles for CAS setup, RAS low and precharge. With these values, a fully saturated backlog of eight cycles finishes well inside one interval. That lets the bench count burst lengths exactly, both with and without a waiting access, and against the yield threshold of 4.

// File: rtl/drf_pkg.sv
package drf_pkg;
  typedef enum logic [1:0] {PH_PAUSE, PH_INIT, PH_RUN} phase_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_CSR, SQ_RAS, SQ_RP} seq_e;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int at_least1(input int a);
    return (a < 1) ? 1 : a;
  endfunction
endpackage

// File: rtl/drf_down_timer.sv
module drf_down_timer #(
  parameter int LOAD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int W = $clog2(LOAD + 1);
  localparam logic [W-1:0] LAST = W'(LOAD - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= LAST;
    else if (!en_i || cnt_q == '0)   cnt_q <= LAST;
    else                             cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = en_i && (cnt_q == '0);
endmodule

// File: rtl/drf_pend_ctr.sv
module drf_pend_ctr #(
  parameter int MAX = 8,
  localparam int W = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP = W'(MAX);

  logic [W-1:0] cnt_q;
  logic         inc_eff, dec_eff;

  assign dec_eff = dec_i && (cnt_q != '0);
  // full counter drops the new request unless one retires in the same cycle
  assign inc_eff = inc_i && ((cnt_q != TOP) || dec_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      case ({inc_eff, dec_eff})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/drf_cbr_seq.sv
module drf_cbr_seq import drf_pkg::*; #(
  parameter int T_CSR = 1,
  parameter int T_RAS = 5,
  parameter int T_RP  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int MAXT = (T_CSR > T_RAS) ? ((T_CSR > T_RP) ? T_CSR : T_RP)
                                        : ((T_RAS > T_RP) ? T_RAS : T_RP);
  localparam int CW = $clog2(MAXT + 1);
  localparam logic [CW-1:0] L_CSR = CW'(T_CSR - 1);
  localparam logic [CW-1:0] L_RAS = CW'(T_RAS - 1);
  localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);

  seq_e         st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (start_i) begin
          st_q  <= SQ_CSR;
          cnt_q <= L_CSR;
        end
        SQ_CSR: if (cnt_q == '0) begin
          st_q  <= SQ_RAS;
          cnt_q <= L_RAS;
        end else cnt_q <= cnt_q - 1'b1;
        SQ_RAS: if (cnt_q == '0) begin
          st_q  <= SQ_RP;
          cnt_q <= L_RP;
        end else cnt_q <= cnt_q - 1'b1;
        default: if (cnt_q == '0) st_q <= SQ_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end

  assign busy_o  = (st_q != SQ_IDLE);
  assign done_o  = (st_q == SQ_RP) && (cnt_q == '0);
  assign cas_n_o = !((st_q == SQ_CSR) || (st_q == SQ_RAS));
  assign ras_n_o = (st_q != SQ_RAS);
endmodule

// File: rtl/drf_refresh_sequencer.sv
module drf_refresh_sequencer import drf_pkg::*; #(
  parameter int CLK_NS      = 10,
  parameter int REFRESH_NS  = 64_000_000,
  parameter int ROWS        = 4096,
  parameter int PAUSE_NS    = 200_000,
  parameter int INIT_CYCLES = 8,
  parameter int CSR_NS      = 10,
  parameter int RAS_NS      = 50,
  parameter int RC_NS       = 84,
  parameter int PEND_MAX    = 8,
  parameter int YIELD_THR   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_gnt_i,
  input  logic acc_wait_i,
  output logic ref_req_o,
  output logic ready_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);
  localparam int INTERVAL_CYC = at_least1(REFRESH_NS / ROWS / CLK_NS);
  localparam int PAUSE_CYC    = at_least1(ceil_div(PAUSE_NS, CLK_NS));
  localparam int T_CSR        = at_least1(ceil_div(CSR_NS, CLK_NS));
  localparam int T_RAS        = at_least1(ceil_div(RAS_NS, CLK_NS));
  localparam int T_RP         = at_least1(ceil_div(RC_NS, CLK_NS) - T_RAS);
  localparam int PW           = $clog2(PEND_MAX + 1);
  localparam int IW           = $clog2(INIT_CYCLES + 1);

  phase_e        phase_q;
  logic [IW-1:0] init_left_q;
  logic [PW-1:0] pend_q;
  logic          pause_tick, ref_tick, busy, done, seq_start, yield;

  drf_down_timer #(.LOAD(PAUSE_CYC)) u_pause (
    .clk_i, .rst_ni, .en_i(phase_q == PH_PAUSE), .tick_o(pause_tick)
  );

  drf_down_timer #(.LOAD(INTERVAL_CYC)) u_interval (
    .clk_i, .rst_ni, .en_i(ready_o), .tick_o(ref_tick)
  );

  drf_pend_ctr #(.MAX(PEND_MAX)) u_pend (
    .clk_i, .rst_ni, .inc_i(ref_tick), .dec_i(done && ready_o), .cnt_o(pend_q)
  );

  drf_cbr_seq #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_seq (
    .clk_i, .rst_ni, .start_i(seq_start), .busy_o(busy), .done_o(done),
    .ras_n_o, .cas_n_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_PAUSE;
      init_left_q <= IW'(INIT_CYCLES);
    end else begin
      case (phase_q)
        PH_PAUSE: if (pause_tick) phase_q <= PH_INIT;
        PH_INIT: if (done) begin
          init_left_q <= init_left_q - 1'b1;
          if (init_left_q == IW'(1)) phase_q <= PH_RUN;
        end
        default: phase_q <= PH_RUN;
      endcase
    end
  end

  assign ready_o   = (phase_q == PH_RUN);
  // hand the strobes back early only when the backlog is small
  assign yield     = acc_wait_i && (int'(pend_q) < YIELD_THR);
  assign ref_req_o = ready_o && (busy || ((pend_q != '0) && !yield));
  assign seq_start = !busy && ((phase_q == PH_INIT) ||
                               (ready_o && ref_gnt_i && ref_req_o));
  assign we_n_o    = 1'b1;
endmodule

// File: rtl/drf_refresh_sequencer_chk.sv
module drf_refresh_sequencer_chk #(
  parameter int PEND_MAX = 8,
  parameter int T_RAS    = 5,
  parameter int PW       = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ras_n_o,
  input logic          cas_n_o,
  input logic          ready_o,
  input logic          ref_req_o,
  input logic [PW-1:0] pend_q
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       low_cnt <= '0;
    else if (!ras_n_o) low_cnt <= low_cnt + 1'b1;
    else               low_cnt <= '0;
  end

  // R4
  ras_after_cas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));
  // R4
  cas_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> !cas_n_o);
  // R5
  ras_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (low_cnt == 16'(T_RAS)));
  // R3
  req_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !ref_req_o);
  // R3
  ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  // R8
  pend_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pend_q) <= PEND_MAX);
  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ref_req_o) |-> (ras_n_o && cas_n_o));
endmodule

bind drf_refresh_sequencer drf_refresh_sequencer_chk #(
  .PEND_MAX(PEND_MAX), .T_RAS(T_RAS), .PW(PW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
  .ready_o(ready_o), .ref_req_o(ref_req_o), .pend_q(pend_q)
);

// File: tb/drf_refresh_sequencer_test.sv
module drf_refresh_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_NS     = 10;
  localparam int REFRESH_NS = 8_192_000;
  localparam int ROWS       = 4096;
  localparam int PAUSE_NS   = 300;
  // expected timing derived from the requirements
  localparam int INTERVAL = REFRESH_NS / ROWS / CLK_NS;        // 200
  localparam int PAUSE    = (PAUSE_NS + CLK_NS - 1) / CLK_NS;  // 30
  localparam int TCSR     = 1;
  localparam int TRAS     = 5;
  localparam int TRP      = 9 - 5;
  localparam int NINIT    = 8;
  // {deferred ticks, access waiting, expected burst length}
  localparam int NV = 8;
  localparam int VEC [NV][3] = '{
    '{1, 0, 1}, '{3, 0, 3}, '{5, 0, 5}, '{8, 0, 8},
    '{12, 0, 8}, '{5, 1, 2}, '{12, 1, 5}, '{3, 1, 0}
  };

  logic clk = 0, rst_n = 0, gnt = 0, acc_wait = 0;
  logic req, ready, ras_n, cas_n, we_n;
  int n_checks = 0, n_err = 0, cyc = 0, gnt_mode = 2;
  int ras_falls = 0, cas_low_run = 0, ras_low_run = 0, ras_high_run = 0;
  bit mon_en = 0, prev_ras = 1, prev_cas = 1, finished = 0;

  drf_refresh_sequencer #(.CLK_NS(CLK_NS), .REFRESH_NS(REFRESH_NS),
                          .ROWS(ROWS), .PAUSE_NS(PAUSE_NS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_gnt_i(gnt), .acc_wait_i(acc_wait),
    .ref_req_o(req), .ready_o(ready), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .we_n_o(we_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    case (gnt_mode)
      0: gnt = 0;
      1: gnt = req;
      default: gnt = 1;
    endcase
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // strobe monitor
  always @(negedge clk) begin
    if (mon_en) begin
      if (we_n !== 1'b1) chk(0, "R6 we_n", we_n, 1);
      if (!ready && req) chk(0, "R3 req before ready", req, 0);
      if (cas_n && !ras_n) chk(0, "R4 cas high under ras", cas_n, 0);
      if (prev_ras && !ras_n) begin
        chk(!cas_n && cas_low_run == TCSR, "R4 cas lead", cas_low_run, TCSR);
        chk(we_n == 1'b1, "R6 we at ras fall", we_n, 1);
        if (ras_falls > 0)
          chk(ras_high_run >= TRP + TCSR, "R5 ras precharge", ras_high_run, TRP + TCSR);
        ras_falls++;
      end
      if (!prev_ras && ras_n) begin
        chk(ras_low_run == TRAS, "R5 ras width", ras_low_run, TRAS);
        chk(cas_n == 1'b1, "R4 cas rise with ras", cas_n, 1);
      end
      cas_low_run  = (!cas_n && ras_n) ? cas_low_run + 1 : 0;
      ras_low_run  = !ras_n ? ras_low_run + 1 : 0;
      ras_high_run = ras_n ? ras_high_run + 1 : 0;
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  task automatic wait_rise(output int at);
    bit p;
    p = req;
    forever begin
      @(negedge clk);
      if (req && !p) break;
      p = req;
    end
    at = cyc;
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!finished) begin
      chk(0, "watchdog", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    int n, na, nb, f0, t0;
    repeat (4) @(negedge clk);
    // R1 reset state, grant forced on
    chk({ras_n, cas_n, we_n} == 3'b111, "R1 strobes", {ras_n, cas_n, we_n}, 7);
    chk(!ready && !req, "R1 ready/req", {ready, req}, 0);
    rst_n = 1;
    mon_en = 1;
    // R2 pause
    n = 0;
    while (cas_n) begin @(negedge clk); n++; end
    chk((n - 1) >= PAUSE && (n - 1) <= PAUSE + 2, "R2 pause", n - 1, PAUSE);
    // R3 init count
    while (!ready) @(negedge clk);
    chk(ras_falls == NINIT, "R3 init cycles", ras_falls, NINIT);
    chk(ready == 1'b1, "R3 ready", ready, 1);
    chk(req == 1'b0, "R9 idle req", req, 0);
    // R7 periodic
    gnt_mode = 1;
    wait_rise(na);
    while (req) @(negedge clk);
    wait_rise(nb);
    chk(nb - na == INTERVAL, "R7 spacing", nb - na, INTERVAL);
    f0 = ras_falls;
    repeat (5 * INTERVAL - 50) @(negedge clk);
    chk(ras_falls - f0 == 5, "R7 count", ras_falls - f0, 5);
    // R8/R10 deferral table
    for (int i = 0; i < NV; i++) begin
      gnt_mode = 1;
      acc_wait = 0;
      repeat (120) @(negedge clk);
      wait_rise(t0);
      while (req) @(negedge clk);
      gnt_mode = 0;
      while (cyc < t0 + VEC[i][0] * INTERVAL + 3) @(negedge clk);
      chk(req == 1'b1, "R9 pending req", req, 1);
      acc_wait = VEC[i][1][0];
      gnt_mode = 2;
      f0 = ras_falls;
      repeat (150) @(negedge clk);
      chk(ras_falls - f0 == VEC[i][2],
          VEC[i][1] != 0 ? "R10 yield burst" : "R8 burst", ras_falls - f0, VEC[i][2]);
      chk(req == 1'b0, "R9 req after burst", req, 0);
      if (VEC[i][1] != 0) begin
        acc_wait = 0;
        @(negedge clk);
        chk(req == 1'b1, "R10 req on wait drop", req, 1);
      end
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule